// File: doc/BRIEF.md
# Region Relocation Permission Check

This block decides, for each address a core presents, whether an access may proceed while a compacting garbage collector relocates memory region by region. Every physical page is reachable through two virtual aliases that differ in one address bit, the toggle bit. A per-region permission bitmap records, for each region, which value of the toggle bit is currently allowed. The region is picked by a field of address bits starting at bit 17, so each region spans 131072 bytes (16384 eight-byte pointers). With one bitmap word, bits 22:17 pick one of 64 regions; each extra word adds index bits directly above bit 22 that pick the word, up to four words and 256 regions.

The collector flips a region between "old view allowed" and "new view allowed" by inverting one bitmap bit, or loads a whole bitmap word at once. The position of the toggle bit is itself a configuration register. A check request carries a kind: a plain 0/1 result, a branch condition, or a checked load that raises an exception request when denied. The verdict is registered and appears one cycle after the request.

Top module: `region_perm_check`

## Requirements
- R1: After a synchronous reset every bitmap bit is 0, the toggle bit position is 47, and out_valid, out_result, out_taken and out_exc are 0.
- R2: With the default four bitmap words, address bits 22:17 give the bit number inside a word and bits 24:23 give the word number (region number = bits 24:17, word = region/64, bit = region mod 64); all other address bits except the toggle bit have no effect on the verdict.
- R3: An access is permitted when the address bit at the toggle position equals the selected bitmap bit, and denied otherwise.
- R4: A request with chk_valid high produces out_valid high on the next cycle; a cycle without a request produces out_valid low on the next cycle.
- R5: chk_kind 0 (result) sets out_result to the deny value; kind 1 (branch) sets out_taken to the deny value; kind 2 (checked load) sets out_exc to the deny value; kind 3 is reserved and raises none of the three flags. At most one flag is high, and only with out_valid.
- R6: A word write (bmp_we) replaces all 64 bits of the bitmap word chosen by bmp_sel with bmp_wdata.
- R7: A flip (flip_en) inverts exactly the bitmap bit of region flip_region (word = flip_region[7:6], bit = flip_region[5:0]) and leaves every other bit unchanged.
- R8: A check in the same cycle as a word write, a flip or a toggle-position write is judged with the values held before that cycle's update.
- R9: A toggle-position write whose value lies inside the region-index bits (17 to 24 with the default four words) is ignored; any value outside that field, including 16 and 25, is accepted.
- R10: When a word write and a flip target the same word in one cycle the word write wins; when they target different words both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bmp_we | input | 1 | Bitmap word write strobe |
| bmp_sel | input | 2 | Bitmap word number for a word write |
| bmp_wdata | input | 64 | New bitmap word contents |
| flip_en | input | 1 | Single-region flip strobe |
| flip_region | input | 8 | Region whose bitmap bit is inverted |
| tpos_we | input | 1 | Toggle bit position write strobe |
| tpos_wdata | input | 6 | New toggle bit position |
| chk_valid | input | 1 | Check request |
| chk_kind | input | 2 | Check kind: 0 result, 1 branch, 2 checked load, 3 reserved |
| chk_addr | input | 64 | Virtual address to check |
| out_valid | output | 1 | Registered verdict valid |
| out_result | output | 1 | 0/1 result: 1 when denied (kind 0) |
| out_taken | output | 1 | Branch taken when denied (kind 1) |
| out_exc | output | 1 | Exception request for a denied checked load (kind 2) |

## Verification
The assertions take for granted that reset is held for at least one clock edge before any request, and that chk_kind carries a defined 2-bit value whenever chk_valid is high. The toggle-position legality property assumes the write data is a defined number, which it compares against the index field limits computed from the parameters. The stimulus drives every input on the falling edge from a known idle state, sets all strobes to zero between scenarios, and only uses the default parameter set, so the field bounds the checker uses match the ones the bench model uses.

// File: rtl/region_perm_pkg.sv
package region_perm_pkg;

  typedef enum logic [1:0] {
    CK_RESULT = 2'd0,
    CK_BRANCH = 2'd1,
    CK_LOAD   = 2'd2,
    CK_RSVD   = 2'd3
  } chk_kind_e;

  // A toggle position is usable only outside the region-index field.
  function automatic logic tpos_ok(input int unsigned pos,
                                   input int unsigned idx_lo,
                                   input int unsigned idx_w,
                                   input int unsigned addr_w);
    return (pos < addr_w) && ((pos < idx_lo) || (pos >= idx_lo + idx_w));
  endfunction

endpackage

// File: rtl/region_perm_decode.sv
module region_perm_decode #(
  parameter int ADDR_W = 64,
  parameter int IDX_LO = 17,
  parameter int BIT_W  = 6,
  parameter int SEL_W  = 2,
  parameter int SEL_USED = 2,
  parameter int TPOS_W = 6
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [TPOS_W-1:0] tpos,
  output logic [SEL_W-1:0]  word_sel,
  output logic [BIT_W-1:0]  bit_sel,
  output logic              tog
);

  assign bit_sel = addr[IDX_LO +: BIT_W];
  assign tog     = addr[tpos];

  generate
    if (SEL_USED > 0) begin : g_multi
      assign word_sel = addr[IDX_LO + BIT_W +: SEL_USED];
    end else begin : g_single
      assign word_sel = '0;
    end
  endgenerate

endmodule

// File: rtl/region_perm_bitmap.sv
module region_perm_bitmap #(
  parameter int NUM_WORDS = 4,
  parameter int WORD_W    = 64,
  parameter int SEL_W     = 2,
  parameter int BIT_W     = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              fl_en,
  input  logic [SEL_W-1:0]  fl_sel,
  input  logic [BIT_W-1:0]  fl_bit,
  input  logic [SEL_W-1:0]  rd_sel,
  input  logic [BIT_W-1:0]  rd_bit,
  output logic              rd_val
);

  logic [WORD_W-1:0] words [NUM_WORDS];

  generate
    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
      always_ff @(posedge clk) begin
        if (rst) begin
          words[g] <= '0;
        end else if (wr_en && (wr_sel == SEL_W'(g))) begin
          words[g] <= wr_data;
        end else if (fl_en && (fl_sel == SEL_W'(g))) begin
          words[g][fl_bit] <= ~words[g][fl_bit];
        end
      end
    end
  endgenerate

  // Read reflects the state before this cycle's update.
  always_comb begin
    rd_val = 1'b0;
    for (int i = 0; i < NUM_WORDS; i++) begin
      if (rd_sel == SEL_W'(i)) rd_val = words[i][rd_bit];
    end
  end

endmodule

// File: rtl/region_perm_verdict.sv
module region_perm_verdict
  import region_perm_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      req,
  input  chk_kind_e kind,
  input  logic      tog,
  input  logic      perm_bit,
  output logic      out_valid,
  output logic      out_result,
  output logic      out_taken,
  output logic      out_exc
);

  logic deny;
  assign deny = tog ^ perm_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= 1'b0;
      out_taken  <= 1'b0;
      out_exc    <= 1'b0;
    end else begin
      out_valid  <= req;
      out_result <= req && (kind == CK_RESULT) && deny;
      out_taken  <= req && (kind == CK_BRANCH) && deny;
      out_exc    <= req && (kind == CK_LOAD)   && deny;
    end
  end

endmodule

// File: rtl/region_perm_check.sv
module region_perm_check
  import region_perm_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int IDX_LO    = 17,
  parameter int WORD_W    = 64,
  parameter int NUM_WORDS = 4,
  parameter int TPOS_RST  = 47,
  localparam int BIT_W    = $clog2(WORD_W),
  localparam int SEL_USED = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 0,
  localparam int SEL_W    = (SEL_USED > 0) ? SEL_USED : 1,
  localparam int IDX_W    = BIT_W + SEL_USED,
  localparam int TPOS_W   = $clog2(ADDR_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bmp_we,
  input  logic [SEL_W-1:0]  bmp_sel,
  input  logic [WORD_W-1:0] bmp_wdata,
  input  logic              flip_en,
  input  logic [IDX_W-1:0]  flip_region,
  input  logic              tpos_we,
  input  logic [TPOS_W-1:0] tpos_wdata,
  input  logic              chk_valid,
  input  logic [1:0]        chk_kind,
  input  logic [ADDR_W-1:0] chk_addr,
  output logic              out_valid,
  output logic              out_result,
  output logic              out_taken,
  output logic              out_exc
);

  logic [TPOS_W-1:0] tpos_q;
  logic [SEL_W-1:0]  word_sel;
  logic [BIT_W-1:0]  bit_sel;
  logic              tog;
  logic              perm_bit;
  logic [SEL_W-1:0]  flip_word;
  logic [BIT_W-1:0]  flip_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      tpos_q <= TPOS_W'(TPOS_RST);
    end else if (tpos_we && tpos_ok(int'(tpos_wdata), IDX_LO, IDX_W, ADDR_W)) begin
      tpos_q <= tpos_wdata;
    end
  end

  assign flip_bit = flip_region[BIT_W-1:0];
  generate
    if (SEL_USED > 0) begin : g_flip_multi
      assign flip_word = flip_region[IDX_W-1:BIT_W];
    end else begin : g_flip_single
      assign flip_word = '0;
    end
  endgenerate

  region_perm_decode #(
    .ADDR_W(ADDR_W), .IDX_LO(IDX_LO), .BIT_W(BIT_W),
    .SEL_W(SEL_W), .SEL_USED(SEL_USED), .TPOS_W(TPOS_W)
  ) u_decode (
    .addr(chk_addr), .tpos(tpos_q),
    .word_sel(word_sel), .bit_sel(bit_sel), .tog(tog)
  );

  region_perm_bitmap #(
    .NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W), .SEL_W(SEL_W), .BIT_W(BIT_W)
  ) u_bitmap (
    .clk(clk), .rst(rst),
    .wr_en(bmp_we), .wr_sel(bmp_sel), .wr_data(bmp_wdata),
    .fl_en(flip_en), .fl_sel(flip_word), .fl_bit(flip_bit),
    .rd_sel(word_sel), .rd_bit(bit_sel), .rd_val(perm_bit)
  );

  region_perm_verdict u_verdict (
    .clk(clk), .rst(rst),
    .req(chk_valid), .kind(chk_kind_e'(chk_kind)),
    .tog(tog), .perm_bit(perm_bit),
    .out_valid(out_valid), .out_result(out_result),
    .out_taken(out_taken), .out_exc(out_exc)
  );

endmodule

// File: rtl/region_perm_check_sva.sv
module region_perm_check_sva #(
  parameter int TPOS_W   = 6,
  parameter int IDX_LO   = 17,
  parameter int IDX_W    = 8,
  parameter int TPOS_RST = 47
) (
  input logic              clk,
  input logic              rst,
  input logic              chk_valid,
  input logic [1:0]        chk_kind,
  input logic              tpos_we,
  input logic [TPOS_W-1:0] tpos_wdata,
  input logic [TPOS_W-1:0] tpos_q,
  input logic              out_valid,
  input logic              out_result,
  input logic              out_taken,
  input logic              out_exc
);

  logic wr_inside;
  assign wr_inside = (int'(tpos_wdata) >= IDX_LO) && (int'(tpos_wdata) < IDX_LO + IDX_W);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_result && !out_taken && !out_exc &&
             tpos_q == TPOS_W'(TPOS_RST)));

  // R4
  req_to_valid_chk: assert property (@(posedge clk) disable iff (rst)
    chk_valid |=> out_valid);

  // R4
  idle_to_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !chk_valid |=> !out_valid);

  // R5
  one_flag_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({out_result, out_taken, out_exc}));

  // R5
  flag_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (out_result || out_taken || out_exc) |-> out_valid);

  // R5
  rsvd_kind_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (chk_valid && chk_kind == 2'd3) |=> !(out_result || out_taken || out_exc));

  // R5
  result_kind_only_chk: assert property (@(posedge clk) disable iff (rst)
    (chk_valid && chk_kind == 2'd0) |=> (!out_taken && !out_exc));

  // R9
  tpos_inside_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (tpos_we && wr_inside) |=> $stable(tpos_q));

endmodule

bind region_perm_check region_perm_check_sva #(
  .TPOS_W(TPOS_W), .IDX_LO(IDX_LO), .IDX_W(IDX_W), .TPOS_RST(TPOS_RST)
) u_sva (
  .clk(clk), .rst(rst), .chk_valid(chk_valid), .chk_kind(chk_kind),
  .tpos_we(tpos_we), .tpos_wdata(tpos_wdata), .tpos_q(tpos_q),
  .out_valid(out_valid), .out_result(out_result),
  .out_taken(out_taken), .out_exc(out_exc)
);

// File: tb/test_region_perm_check.sv
module test_region_perm_check;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        bmp_we;
  logic [1:0]  bmp_sel;
  logic [63:0] bmp_wdata;
  logic        flip_en;
  logic [7:0]  flip_region;
  logic        tpos_we;
  logic [5:0]  tpos_wdata;
  logic        chk_valid;
  logic [1:0]  chk_kind;
  logic [63:0] chk_addr;
  logic        out_valid, out_result, out_taken, out_exc;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  logic [63:0] m_bmp [4];
  int          m_tpos;

  always #(CLK_PERIOD/2) clk = ~clk;

  region_perm_check i_region_perm_check (
    .clk(clk), .rst(rst),
    .bmp_we(bmp_we), .bmp_sel(bmp_sel), .bmp_wdata(bmp_wdata),
    .flip_en(flip_en), .flip_region(flip_region),
    .tpos_we(tpos_we), .tpos_wdata(tpos_wdata),
    .chk_valid(chk_valid), .chk_kind(chk_kind), .chk_addr(chk_addr),
    .out_valid(out_valid), .out_result(out_result),
    .out_taken(out_taken), .out_exc(out_exc)
  );

  task automatic idle();
    bmp_we = 0; bmp_sel = 0; bmp_wdata = 0;
    flip_en = 0; flip_region = 0;
    tpos_we = 0; tpos_wdata = 0;
    chk_valid = 0; chk_kind = 0; chk_addr = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [63:0] mk_addr(input int region, input logic tog,
                                          input logic [63:0] noise);
    logic [63:0] a;
    a = noise & ~(64'hFF << 17);
    a[m_tpos] = 1'b0;
    a = a | (64'(region) << 17);
    a[m_tpos] = tog;
    return a;
  endfunction

  function automatic logic m_deny(input logic [63:0] a);
    int r;
    r = int'(a[24:17]);
    return a[m_tpos] != m_bmp[r / 64][r % 64];
  endfunction

  task automatic expect_out(input string req, input logic v, input logic res,
                            input logic tk, input logic ex);
    tests++;
    if ({out_valid, out_result, out_taken, out_exc} !== {v, res, tk, ex}) begin
      fails++;
      $display("FAIL %s: got v/res/tk/exc=%b%b%b%b expected %b%b%b%b", req,
               out_valid, out_result, out_taken, out_exc, v, res, tk, ex);
    end
  endtask

  // Drive one check (plus whatever the caller already set), compute with the old model.
  task automatic check(input string req, input int kind, input logic [63:0] a);
    logic d;
    d = m_deny(a);
    chk_valid = 1; chk_kind = 2'(kind); chk_addr = a;
    tick();
    expect_out(req, 1'b1, d && kind == 0, d && kind == 1, d && kind == 2);
    idle();
  endtask

  task automatic wr_word(input int sel, input logic [63:0] d);
    bmp_we = 1; bmp_sel = 2'(sel); bmp_wdata = d;
    tick(); idle();
    m_bmp[sel] = d;
  endtask

  task automatic flip(input int region);
    flip_en = 1; flip_region = 8'(region);
    tick(); idle();
    m_bmp[region / 64][region % 64] = ~m_bmp[region / 64][region % 64];
  endtask

  task automatic wr_tpos(input int p);
    tpos_we = 1; tpos_wdata = 6'(p);
    tick(); idle();
    if (p < 17 || p > 24) m_tpos = p;
  endtask

  task automatic t_reset();
    idle();
    rst = 1; tick(); tick(); rst = 0;
    for (int i = 0; i < 4; i++) m_bmp[i] = '0;
    m_tpos = 47;
    expect_out("R1 outputs after reset", 0, 0, 0, 0);
    check("R1 cleared bitmap allows toggle 0", 0, mk_addr(0, 1'b0, 0));
    check("R1 toggle at bit 47 denied", 0, mk_addr(200, 1'b1, 0));
  endtask

  task automatic t_idle();
    tick();
    expect_out("R4 no request no valid", 0, 0, 0, 0);
  endtask

  task automatic t_words();
    wr_word(0, 64'hA5A5_0F0F_3C3C_0001);
    wr_word(3, 64'h8000_0000_0000_0001);
    check("R6 R3 word0 bit0 set tog1 allowed", 0, mk_addr(0, 1'b1, 64'h1_2345));
    check("R3 word0 bit0 set tog0 denied", 0, mk_addr(0, 1'b0, 64'h1_FFFF));
    check("R2 region192 uses word3 bit0", 0, mk_addr(192, 1'b1, 0));
    check("R2 region255 word3 bit63", 0, mk_addr(255, 1'b1, 64'h0000_00F0_FE00_0000));
    check("R2 region254 word3 bit62 clear", 0, mk_addr(254, 1'b1, 0));
    check("R2 region64 word1 clear", 0, mk_addr(64, 1'b1, 0));
    check("R6 word0 bit2 region2", 0, mk_addr(2, 1'b0, 64'h0000_7FFF_FE00_FFFF));
  endtask

  task automatic t_flip();
    flip(130);
    check("R7 flipped region130 allows tog1", 0, mk_addr(130, 1'b1, 0));
    check("R7 neighbour region131 unchanged", 0, mk_addr(131, 1'b0, 0));
    check("R7 region2 other word unchanged", 0, mk_addr(2, 1'b0, 0));
    flip(130);
    check("R7 second flip restores region130", 0, mk_addr(130, 1'b1, 0));
  endtask

  task automatic t_kinds();
    logic [63:0] den, ok;
    den = mk_addr(70, 1'b1, 0);
    ok  = mk_addr(70, 1'b0, 0);
    check("R5 result kind denied", 0, den);
    check("R5 branch kind taken", 1, den);
    check("R5 load kind exception", 2, den);
    check("R5 reserved kind no flag", 3, den);
    check("R5 load kind permitted no exception", 2, ok);
    check("R5 branch kind not taken", 1, ok);
  endtask

  task automatic t_same_cycle();
    bmp_we = 1; bmp_sel = 1; bmp_wdata = '1;
    check("R8 word write same cycle uses old", 0, mk_addr(64, 1'b1, 0));
    m_bmp[1] = '1;
    check("R8 new word visible next cycle", 0, mk_addr(64, 1'b1, 0));
    flip_en = 1; flip_region = 8'd65;
    check("R8 flip same cycle uses old", 1, mk_addr(65, 1'b1, 0));
    m_bmp[1][1] = 1'b0;
    check("R8 flip visible next cycle", 1, mk_addr(65, 1'b1, 0));
    tpos_we = 1; tpos_wdata = 6'd30;
    check("R8 tpos write same cycle uses old", 0, mk_addr(64, 1'b1, 0));
    m_tpos = 30;
    check("R8 new tpos visible next cycle", 0, mk_addr(64, 1'b0, 64'h0000_8000_0000_0000));
  endtask

  task automatic t_tpos();
    wr_tpos(5);
    check("R9 legal tpos 5 used", 0, mk_addr(0, 1'b1, 0));
    check("R9 legal tpos 5 denied", 0, mk_addr(0, 1'b0, 0));
    wr_tpos(20);
    check("R9 inside write ignored", 0, mk_addr(0, 1'b0, 64'h0000_0000_0010_0000));
    wr_tpos(17);
    check("R9 low edge 17 ignored", 0, mk_addr(0, 1'b1, 0));
    wr_tpos(24);
    check("R9 high edge 24 ignored", 2, mk_addr(0, 1'b0, 0));
    wr_tpos(16);
    check("R9 below field 16 accepted", 0, mk_addr(0, 1'b0, 64'h20));
    wr_tpos(25);
    check("R9 above field 25 accepted", 1, mk_addr(0, 1'b0, 64'h1_0000));
  endtask

  task automatic t_wr_flip();
    bmp_we = 1; bmp_sel = 2; bmp_wdata = 64'h0;
    flip_en = 1; flip_region = 8'd133;
    tick(); idle();
    m_bmp[2] = 64'h0;
    check("R10 same word write wins over flip", 0, mk_addr(133, 1'b1, 0));
    bmp_we = 1; bmp_sel = 0; bmp_wdata = 64'hFFFF_0000_FFFF_0000;
    flip_en = 1; flip_region = 8'd200;
    tick(); idle();
    m_bmp[0] = 64'hFFFF_0000_FFFF_0000;
    m_bmp[3][8] = ~m_bmp[3][8];
    check("R10 other word flip applied", 0, mk_addr(200, 1'b1, 0));
    check("R10 other word write applied", 0, mk_addr(16, 1'b1, 0));
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        fails++;
        $display("FAIL watchdog: got %0d cycles expected under 100000", cycles);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_idle();
    t_words();
    t_flip();
    t_kinds();
    t_same_cycle();
    t_tpos();
    t_wr_flip();
    t_idle();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule